// File: doc/BRIEF.md
# Keyboard Auto-Repeat Controller

This block sits behind a keyboard matrix scanner. Each scan pass of the scanner delivers one scan code, which is either a reserved "no key" code or the code of the key being held. The block compares each pass with the pass before it. It emits one key event when a key is first pressed. If the same key stays down, it waits through a fixed initial delay and then emits repeat events at a fixed interval.

A two-bit repeat-mode register chooses which keys repeat. The choices are every key, no key, or only a fixed list of editing keys: the two cursor keys, space, and insert/delete. The delay and the interval are counted in scan passes. They are constants and cannot be programmed.

Scan passes come in on a valid/ready stream, and key events leave on another valid/ready stream. The block holds one output event. When the consumer stalls the event stream, the block stops taking scan passes. No pass is lost and none is counted twice. The mode-write pins are plain control pins.

Top module: `key_repeat_ctl`

## Requirements
- R1: After reset, the repeat mode is "all keys repeat" (mode value 2'b10), `evt_valid` is low and `scan_ready` is high. The previous-pass code starts as the no-key code 8'hFF.
- R2: Mode encoding, written through `mode_wr`/`mode_wdata`:
  - If bit 1 is 1, every key repeats.
  - If bit 1 is 0 and bit 0 is 1, no key repeats.
  - If both bits are 0, only codes 8'h02, 8'h07, 8'h3C and 8'h00 repeat.
- R3: An accepted pass whose code is not 8'hFF and differs from the previous accepted pass produces exactly one event carrying that code. The event is visible on the cycle after the accepting edge.
- R4: An accepted pass with code 8'hFF produces no event and re-arms the initial delay.
- R5: A repeat-eligible key held on consecutive accepted passes gives one event on each held pass number 20, 24, 28 and so on. Pass 0 is the press. The 16-pass delay then runs into a 4-pass interval.
- R6: Changing from one key directly to a different key restarts the delay. The new key's repeats follow R5, counted from its own press.
- R7: A held key that is not repeat-eligible under the current mode produces no event after its press event.
- R8: Back-pressure:
  - While `evt_valid` is high and `evt_ready` is low, `evt_code` stays stable and `scan_ready` is low.
  - Only passes accepted with `scan_valid && scan_ready` count toward the delay and the interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_valid | input | 1 | A scan pass is offered |
| scan_ready | output | 1 | The block can take a pass |
| scan_code | input | 8 | Code of the pass; 8'hFF means no key |
| mode_wr | input | 1 | Write strobe for the repeat mode |
| mode_wdata | input | 2 | New repeat mode |
| evt_valid | output | 1 | A key event is held |
| evt_ready | input | 1 | The consumer takes the event |
| evt_code | output | 8 | Scan code of the event |

## Verification
The hardest situation to reach is a repeat falling due while the output stage is still held by a stalled consumer. In that case the block must freeze its pass counting rather than drop or merge events. To create it, the bench holds an eligible key for many passes while `evt_ready` follows a pseudo-random pattern, so stalls land on and around the 20th and later passes. A scoreboard model counts only accepted passes. It also covers a mid-delay switch to another key, and a release followed by re-press of the same key. These check that the delay restarts rather than resumes.

// File: rtl/kr_pkg.sv
package kr_pkg;
  localparam int unsigned CODE_W     = 8;
  localparam int unsigned FIRST_WAIT = 16;
  localparam int unsigned REP_GAP    = 4;
  localparam int unsigned WAIT_W     = $clog2(FIRST_WAIT + 1);
  localparam int unsigned GAP_W      = $clog2(REP_GAP + 1);

  typedef enum logic [1:0] {
    RM_SUBSET = 2'b00,
    RM_NONE   = 2'b01,
    RM_ALL    = 2'b10,
    RM_ALL2   = 2'b11
  } rep_mode_e;
endpackage

// File: rtl/kr_match.sv
module kr_match #(
  parameter int unsigned W = 8,
  parameter int unsigned N = 4,
  parameter logic [N*W-1:0] LIST = {8'h02, 8'h07, 8'h3C, 8'h00}
) (
  input  logic [W-1:0] code,
  output logic         hit
);
  logic [N-1:0] match_vec;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match_vec[g] = (code == LIST[g*W +: W]);
  end

  assign hit = |match_vec;
endmodule

// File: rtl/kr_timer.sv
module kr_timer
  import kr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic hold,
  output logic fire
);
  logic [WAIT_W-1:0] wait_q;
  logic [GAP_W-1:0]  gap_q;
  logic              rep_q;

  assign fire = hold && rep_q && (gap_q == GAP_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wait_q <= WAIT_W'(FIRST_WAIT);
      gap_q  <= GAP_W'(REP_GAP);
      rep_q  <= 1'b0;
    end else if (restart) begin
      wait_q <= WAIT_W'(FIRST_WAIT);
      gap_q  <= GAP_W'(REP_GAP);
      rep_q  <= 1'b0;
    end else if (hold) begin
      if (!rep_q) begin
        wait_q <= wait_q - WAIT_W'(1);
        if (wait_q == WAIT_W'(1)) begin
          rep_q <= 1'b1;
          gap_q <= GAP_W'(REP_GAP);
        end
      end else if (gap_q == GAP_W'(1)) begin
        gap_q <= GAP_W'(REP_GAP);
      end else begin
        gap_q <= gap_q - GAP_W'(1);
      end
    end
  end

  AST_WAIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wait_q <= WAIT_W'(FIRST_WAIT)); // R5
  AST_REP_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    rep_q |-> (wait_q == '0)); // R5
  AST_GAP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rep_q |-> (gap_q != '0 && gap_q <= GAP_W'(REP_GAP))); // R5
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!rep_q && wait_q == WAIT_W'(FIRST_WAIT))); // R6
endmodule

// File: rtl/kr_out.sv
module kr_out #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_code,
  input  logic         evt_ready,
  output logic         evt_valid,
  output logic [W-1:0] evt_code,
  output logic         can_take
);
  assign can_take = !evt_valid || evt_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_valid <= 1'b0;
      evt_code  <= '0;
    end else if (load) begin
      evt_valid <= 1'b1;
      evt_code  <= load_code;
    end else if (evt_ready) begin
      evt_valid <= 1'b0;
    end
  end

  AST_EVT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !evt_ready) |=> (evt_valid && $stable(evt_code))); // R8
  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> can_take); // R8
endmodule

// File: rtl/key_repeat_ctl.sv
module key_repeat_ctl
  import kr_pkg::*;
#(
  parameter logic [CODE_W-1:0] NO_KEY  = 8'hFF,
  parameter int unsigned       REP_N   = 4,
  parameter logic [REP_N*CODE_W-1:0] REP_LIST = {8'h02, 8'h07, 8'h3C, 8'h00}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scan_valid,
  output logic              scan_ready,
  input  logic [CODE_W-1:0] scan_code,
  input  logic              mode_wr,
  input  logic [1:0]        mode_wdata,
  output logic              evt_valid,
  input  logic              evt_ready,
  output logic [CODE_W-1:0] evt_code
);
  rep_mode_e         mode_q;
  logic [CODE_W-1:0] prev_q;
  logic              acc, is_key, same, in_list, eligible;
  logic              restart, hold, new_evt, fire, load;
  logic [CODE_W-1:0] load_code;

  always_ff @(posedge clk) begin
    if (!rst_n)       mode_q <= RM_ALL;
    else if (mode_wr) mode_q <= rep_mode_e'(mode_wdata);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   prev_q <= NO_KEY;
    else if (acc) prev_q <= scan_code;
  end

  kr_match #(.W(CODE_W), .N(REP_N), .LIST(REP_LIST)) match_i (
    .code (scan_code),
    .hit  (in_list)
  );

  always_comb begin
    unique case (mode_q)
      RM_ALL, RM_ALL2: eligible = 1'b1;
      RM_NONE:         eligible = 1'b0;
      default:         eligible = in_list;
    endcase
  end

  assign acc       = scan_valid && scan_ready;
  assign is_key    = (scan_code != NO_KEY);
  assign same      = (scan_code == prev_q);
  assign restart   = acc && !(is_key && same);
  assign hold      = acc && is_key && same && eligible;
  assign new_evt   = acc && is_key && !same;
  assign load      = new_evt || fire;
  assign load_code = scan_code;

  kr_timer timer_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .hold    (hold),
    .fire    (fire)
  );

  kr_out #(.W(CODE_W)) out_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_code (load_code),
    .evt_ready (evt_ready),
    .evt_valid (evt_valid),
    .evt_code  (evt_code),
    .can_take  (scan_ready)
  );

  AST_PRESS_EMITS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && scan_code != NO_KEY && scan_code != prev_q)
      |=> (evt_valid && evt_code == $past(scan_code))); // R3
  AST_RELEASE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && scan_code == NO_KEY) |=> !evt_valid); // R4
  AST_IDLE_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc && evt_valid && evt_ready) |=> !evt_valid); // R8
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !evt_ready) |-> !scan_ready); // R8
  AST_NONE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == RM_NONE) |-> !fire); // R7
endmodule

// File: tb/key_repeat_ctl_tb_top.sv
`timescale 1ns/1ps
module key_repeat_ctl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scan_valid = 1'b0;
  logic       scan_ready;
  logic [7:0] scan_code = 8'hFF;
  logic       mode_wr = 1'b0;
  logic [1:0] mode_wdata = 2'b00;
  logic       evt_valid;
  logic       evt_ready = 1'b1;
  logic [7:0] evt_code;

  always #2 clk = ~clk;

  key_repeat_ctl dut_i (
    .clk(clk), .rst_n(rst_n),
    .scan_valid(scan_valid), .scan_ready(scan_ready), .scan_code(scan_code),
    .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_code(evt_code)
  );

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  bit          done  = 1'b0;
  bit          stall_on = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  logic [1:0] m_mode = 2'b10;
  logic [7:0] m_prev = 8'hFF;
  int         m_held = 0;

  function automatic bit m_elig(logic [7:0] c);
    if (m_mode[1]) return 1'b1;
    if (m_mode[0]) return 1'b0;
    return (c == 8'h02 || c == 8'h07 || c == 8'h3C || c == 8'h00);
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver: model computes expected events, pushes them, then offers the pass
  task automatic pass(logic [7:0] c, string tag);
    if (c == 8'hFF) begin
      m_prev = c; m_held = 0;
    end else if (c != m_prev) begin
      exp_q.push_back(c); tag_q.push_back(tag);
      m_prev = c; m_held = 0;
    end else if (m_elig(c)) begin
      m_held++;
      if (m_held >= 20 && ((m_held - 16) % 4) == 0) begin
        exp_q.push_back(c); tag_q.push_back(tag);
      end
    end
    scan_valid = 1'b1;
    scan_code  = c;
    while (!scan_ready) @(negedge clk);
    @(negedge clk);
    scan_valid = 1'b0;
  endtask

  task automatic hold_key(logic [7:0] c, int n, string tag);
    for (int i = 0; i <= n; i++) pass(c, tag);
  endtask

  task automatic set_mode(logic [1:0] m);
    mode_wr = 1'b1; mode_wdata = m;
    @(negedge clk);
    mode_wr = 1'b0;
    m_mode = m;
  endtask

  // evt_ready pattern, changed away from the sampling edge
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    evt_ready = stall_on ? lfsr[0] : 1'b1;
  end

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && evt_valid && !evt_ready)
        check(!scan_ready, "R8 stall blocks scan", scan_ready, 0);
      if (rst_n && evt_valid && evt_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R4/R7 unexpected event", evt_code, 0);
        end else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(evt_code == e, t, evt_code, e);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(evt_valid == 1'b0, "R1 evt_valid after reset", evt_valid, 0);
    check(scan_ready == 1'b1, "R1 scan_ready after reset", scan_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    hold_key(8'h41, 30, "R1 R5 default all-repeat");
    hold_key(8'hFF, 3, "R4 release");
    hold_key(8'h41, 10, "R3 press");
    hold_key(8'h42, 25, "R6 switch restarts delay");
    hold_key(8'hFF, 1, "R4 release");
    hold_key(8'h42, 12, "R4 re-press");
    hold_key(8'hFF, 1, "R4 release");
    hold_key(8'h42, 22, "R4 delay re-armed");
    set_mode(2'b00);
    hold_key(8'h41, 30, "R7 subset ignores other key");
    hold_key(8'h3C, 24, "R2 subset space repeats");
    hold_key(8'h00, 20, "R2 subset code 00 repeats");
    set_mode(2'b01);
    hold_key(8'h3C, 30, "R2 R7 none mode");
    set_mode(2'b11);
    stall_on = 1'b1;
    hold_key(8'h07, 44, "R8 stalled repeats");
    hold_key(8'h02, 3, "R8 R3 stalled press");
    stall_on = 1'b0;
    hold_key(8'hFF, 2, "R4 release");
    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R8 all expected events seen", exp_q.size(), 0);
    check(evt_valid == 1'b0, "R8 output drained", evt_valid, 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule